// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block produces the address stream for a synchronous memory that moves four data words for each address it is given. A load cycle captures an external address and makes it the first address of a burst. Each later advance cycle steps the two low address bits to the next position of the four-word group. The upper bits keep the value that was captured at the load.

The step order is set by a burst-order input that is meant to be tied off. In linear order the low bits count up modulo four from the starting value. In interleaved order the low bits are the starting value XORed with the beat number. The order is captured together with the address at each load, so a change on that input affects only the next burst.

One control input selects the operation. When it is low it requests a load, and when it is high it requests an advance. A chip-select qualifier, sampled on load cycles, decides whether the load starts a burst or deselects the block. Deselecting stops any burst in progress. A clock enable freezes all state.

Top module: `burst_addr_gen`

## Requirements
- R1: After a synchronous reset, `addr_out` is 0 and `burst_active` is 0.
- R2: On an enabled cycle with `adv_ld`=0 and `cs`=1, `addr_out` equals `addr_in` and `burst_active` is 1 one cycle later.
- R3: With `burst_linear`=1 at the load, the low two bits of `addr_out` take the values (s+k) mod 4 for beats k=0,1,2,3, where s is the loaded low value.
- R4: With `burst_linear`=0 at the load, the low two bits of `addr_out` take the values s XOR k for beats k=0,1,2,3.
- R5: While a burst advances, bits above bit 1 of `addr_out` keep the loaded value. An advance from beat 3 returns to beat 0 (the loaded address) with no carry into the upper bits, and the burst stays active.
- R6: On an enabled cycle with `adv_ld`=0 and `cs`=0, `burst_active` becomes 0 and `addr_out` keeps its value.
- R7: On an enabled cycle with `adv_ld`=1 while `burst_active` is 0, `addr_out` does not change and `burst_active` stays 0.
- R8: While `clk_en`=0, `addr_out` and `burst_active` hold their values, whatever the other inputs do.
- R9: A load while a burst is active restarts the burst at the new address, with beat 0 and the newly sampled order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock enable; 0 freezes all state |
| adv_ld | input | 1 | 0 = load new address, 1 = advance the burst |
| cs | input | 1 | Chip-select qualifier, sampled on load cycles |
| burst_linear | input | 1 | Burst order, captured at load: 1 = linear, 0 = interleaved |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current memory address |
| burst_active | output | 1 | A burst is in progress |

## Verification
The assertions expect every input to be a known value on each clock edge after reset. They also expect reset to stay low during a checked window, because each property compares a cycle with the cycle before it. The random stimulus follows these rules: it drives every input to a defined value on the falling edge and asserts reset only at the start. It changes the burst order freely, including during a burst, because the design samples the order only at a load. The stimulus is weighted toward advance cycles so that full four-beat wraps happen often. It also mixes in deselects, idle advances and stalled cycles.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int BURST_LEN = 4;
    localparam int BEAT_W    = $clog2(BURST_LEN);

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_LOAD,
        OP_STOP,
        OP_STEP
    } burst_op_e;

    typedef struct packed {
        logic  active;
        logic  linear;
        beat_t base;
        beat_t beat;
    } burst_state_t;

    function automatic beat_t next_beat(input beat_t b);
        return b + beat_t'(1);
    endfunction

    function automatic beat_t linear_pos(input beat_t base, input beat_t beat);
        return base + beat;
    endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_pkg::*;
(
    input  logic      clk_en,
    input  logic      adv_ld,
    input  logic      cs,
    input  logic      active,
    output burst_op_e op
);

    always_comb begin
        if (!clk_en) begin
            op = OP_HOLD;
        end else if (!adv_ld) begin
            op = cs ? OP_LOAD : OP_STOP;
        end else if (active) begin
            op = OP_STEP;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  burst_op_e    op,
    input  beat_t        load_base,
    input  logic         load_linear,
    output burst_state_t st
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            unique case (op)
                OP_LOAD: begin
                    st.active <= 1'b1;
                    st.linear <= load_linear;
                    st.base   <= load_base;
                    st.beat   <= '0;
                end
                OP_STOP: st.active <= 1'b0;
                OP_STEP: st.beat   <= next_beat(st.beat);
                default: st <= st;
            endcase
        end
    end

    // R9: a load always restarts the beat count at zero
    p_load_restart_r9: assert property (@(posedge clk) disable iff (rst)
        op == OP_LOAD |=> st.beat == '0 && st.active);

endmodule

// File: rtl/burst_seq_map.sv
module burst_seq_map
    import burst_pkg::*;
(
    input  beat_t base,
    input  beat_t beat,
    input  logic  linear,
    output beat_t pos
);

    beat_t lin_pos;
    beat_t ilv_pos;

    assign lin_pos = linear_pos(base, beat);

    for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv_bit
        assign ilv_pos[i] = base[i] ^ beat[i];
    end

    assign pos = linear ? lin_pos : ilv_pos;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              adv_ld,
    input  logic              cs,
    input  logic              burst_linear,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              burst_active
);

    localparam int HI_W = ADDR_W - BEAT_W;

    burst_op_e       op;
    burst_state_t    st;
    beat_t           low_pos;
    logic [HI_W-1:0] hi_q;

    burst_ctrl u_ctrl (
        .clk_en (clk_en),
        .adv_ld (adv_ld),
        .cs     (cs),
        .active (st.active),
        .op     (op)
    );

    burst_beat_ctr u_ctr (
        .clk         (clk),
        .rst         (rst),
        .op          (op),
        .load_base   (addr_in[BEAT_W-1:0]),
        .load_linear (burst_linear),
        .st          (st)
    );

    burst_seq_map u_map (
        .base   (st.base),
        .beat   (st.beat),
        .linear (st.linear),
        .pos    (low_pos)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
        end else if (op == OP_LOAD) begin
            hi_q <= addr_in[ADDR_W-1:BEAT_W];
        end
    end

    assign addr_out     = {hi_q, low_pos};
    assign burst_active = st.active;

    // R2: a selected load shows the external address next cycle
    p_load_addr_r2: assert property (@(posedge clk) disable iff (rst)
        clk_en && !adv_ld && cs |=> addr_out == $past(addr_in) && burst_active);

    // R3: linear order steps the low bits by one
    p_linear_step_r3: assert property (@(posedge clk) disable iff (rst)
        clk_en && adv_ld && burst_active && st.linear
        |=> addr_out[BEAT_W-1:0] == beat_t'($past(addr_out[BEAT_W-1:0]) + 1'b1));

    // R5: upper bits never move during an advance
    p_upper_fixed_r5: assert property (@(posedge clk) disable iff (rst)
        clk_en && adv_ld && burst_active
        |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]) && burst_active);

    // R6: deselect on a load cycle ends the burst, address held
    p_deselect_stop_r6: assert property (@(posedge clk) disable iff (rst)
        clk_en && !adv_ld && !cs |=> !burst_active && $stable(addr_out));

    // R7: advance with no burst is ignored
    p_idle_advance_r7: assert property (@(posedge clk) disable iff (rst)
        clk_en && adv_ld && !burst_active |=> !burst_active && $stable(addr_out));

    // R8: clock enable low freezes the outputs
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(addr_out) && $stable(burst_active));

endmodule

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb;

    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_en = 1'b0;
    logic          adv_ld = 1'b0;
    logic          cs = 1'b0;
    logic          burst_linear = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic          burst_active;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic          e_act = 1'b0;
    logic          e_lin = 1'b0;
    logic [1:0]    e_base = '0;
    logic [1:0]    e_beat = '0;
    logic [AW-3:0] e_hi = '0;

    always #2.5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .clk_en       (clk_en),
        .adv_ld       (adv_ld),
        .cs           (cs),
        .burst_linear (burst_linear),
        .addr_in      (addr_in),
        .addr_out     (addr_out),
        .burst_active (burst_active)
    );

    function automatic logic [1:0] exp_low(input logic [1:0] s, input logic [1:0] k,
                                           input logic lin);
        logic [2:0] sum;
        sum = {1'b0, s} + {1'b0, k};
        return lin ? sum[1:0] : (s ^ k);
    endfunction

    function automatic logic [AW-1:0] exp_addr();
        return {e_hi, exp_low(e_base, e_beat, e_lin)};
    endfunction

    task automatic check(input string tag);
        checks++;
        if (addr_out !== exp_addr() || burst_active !== e_act) begin
            errors++;
            $display("FAIL %s: addr=%h act=%b expected addr=%h act=%b",
                     tag, addr_out, burst_active, exp_addr(), e_act);
        end
    endtask

    task automatic cycle(input logic ce, input logic adv, input logic c,
                         input logic lin, input logic [AW-1:0] a);
        string tag;
        clk_en = ce; adv_ld = adv; cs = c; burst_linear = lin; addr_in = a;
        if (!ce)               tag = "R8 stall hold";
        else if (!adv && c)    tag = e_act ? "R9 reload" : "R2 load";
        else if (!adv)         tag = "R6 deselect";
        else if (!e_act)       tag = "R7 idle advance";
        else if (e_beat == 2'd3) tag = "R5 wrap";
        else                   tag = e_lin ? "R3 linear step" : "R4 interleaved step";
        @(posedge clk);
        if (ce) begin
            if (!adv && c) begin
                e_act = 1'b1; e_lin = lin; e_base = a[1:0]; e_beat = 2'd0; e_hi = a[AW-1:2];
            end else if (!adv) begin
                e_act = 1'b0;
            end else if (e_act) begin
                e_beat = e_beat + 2'd1;
            end
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: expired, actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset state");

        cycle(1, 1, 1, 1, 17'h0_0002);           // R7 idle advance after reset
        cycle(1, 0, 1, 1, 17'h1_0001);           // R2 load, linear start 1
        for (int i = 0; i < 4; i++) cycle(1, 1, 1, 0, '0);  // R3 2,3,0 then R5 wrap to 1
        cycle(1, 0, 1, 0, 17'h0_5A5D);           // R9 reload interleaved start 1
        for (int i = 0; i < 4; i++) cycle(1, 1, 0, 1, '0);  // R4 0,3,2 then wrap
        cycle(1, 0, 1, 1, 17'h1_FFFF);           // R5 no carry at top
        cycle(1, 1, 1, 1, '0);
        cycle(0, 0, 1, 0, 17'h0_1234);           // R8 stall ignores load
        cycle(0, 1, 1, 0, '0);
        cycle(1, 0, 0, 0, 17'h0_0F00);           // R6 deselect
        cycle(1, 1, 1, 1, '0);                   // R7 ignored
        cycle(1, 1, 1, 0, '0);

        for (int i = 0; i < 3000; i++) begin
            int r;
            logic ce, adv, c;
            r   = $urandom_range(0, 99);
            ce  = (r >= 10);
            adv = (r >= 28);
            c   = ($urandom_range(0, 3) != 0);
            cycle(ce, adv, c, 1'($urandom_range(0, 1)), AW'($urandom));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule